// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one starting column address into the sequence of column addresses a DRAM burst visits, one per data beat. A controller pulses `start_i` together with the starting column, a length code and a burst-order bit. From the next cycle on, the block presents one column per cycle on `col_o`, with `valid_o` high, until the burst completes.

The beat order never leaves the aligned block of columns whose size equals the burst length. The bits above that block are held. The bits inside it either count up and wrap (sequential order) or are XORed with the beat index (interleaved order). A terminate input ends the burst early. A new start on the final beat chains the next burst with no idle cycle between them.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: One cycle after `start_i` is sampled high, `valid_o` is 1 and `col_o` equals the captured starting column. This is beat 0 in both orders.
- R3: `len_code_i` selects the number of beats. Code 1 gives 2 beats, code 2 gives 4 beats, code 3 gives 8 beats, and code 0 is treated as 2 beats. An uninterrupted burst holds `valid_o` high for exactly that many consecutive cycles.
- R4: With `ilv_i`=0 (sequential order), the low log2(length) bits of beat k are (start low bits + k) modulo the length.
- R5: With `ilv_i`=1 (interleaved order), the low log2(length) bits of beat k are (start low bits) XOR k.
- R6: The column bits above the aligned block keep their starting value on every beat of a burst.
- R7: `last_o` is 1 only on the final beat (index length-1). It implies `valid_o`. Without a new start, `valid_o` is 0 on the cycle after that beat.
- R8: If `term_i` is high during a valid beat and `start_i` is low, that beat is the last one emitted, and `valid_o` is 0 on the next cycle.
- R9: If `start_i` is high during the final beat, the next cycle carries beat 0 of the new burst with no idle cycle between the bursts.
- R10: The length, order and starting column are captured at the start. Changes to those inputs during a burst do not affect it.
- R11: While the block is idle, `term_i` has no effect. `valid_o` stays 0, and a later burst runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst (sampled at the clock edge) |
| start_col_i | input | COL_W | Starting column address |
| len_code_i | input | 2 | Burst length code (see R3) |
| ilv_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| term_i | input | 1 | Terminate the current burst after this beat |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is present this cycle |
| last_o | output | 1 | Current beat is the final one of the burst |

## Verification
The bench builds the block with its defaults: a 9-bit column and a maximum length code of 3 (8 beats). These values bring every length within reach. Starting columns that sit at an odd offset inside the block, near the top of the column range, and with the upper bits set show wrap-around and preservation of the upper bits in both orders. Beyond full bursts, the bench covers early termination, termination while idle, chaining on the final beat, and input changes during a burst.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bcs_order.sv
module bcs_order #(
  parameter int COL_W       = 9,
  parameter int LEN_LOG_MAX = 3,
  localparam int CW = $clog2(LEN_LOG_MAX + 1)
) (
  input  logic [COL_W-1:0]       base_i,
  input  logic [LEN_LOG_MAX-1:0] beat_i,
  input  logic [CW-1:0]          len_log_i,
  input  bcs_pkg::burst_order_e  order_i,
  output logic [COL_W-1:0]       col_o
);
  // Beat column: bits above the aligned block are kept, low bits advance
  // by add-and-wrap or by XOR with the beat index.
  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0]       base,
    input logic [LEN_LOG_MAX-1:0] k,
    input logic [CW-1:0]          len_log,
    input bcs_pkg::burst_order_e  ord
  );
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] kx;
    logic [COL_W-1:0] low;
    mask = (COL_W'(1) << len_log) - COL_W'(1);
    kx   = COL_W'(k);
    low  = (ord == bcs_pkg::ORD_ILV) ? (base ^ kx) : (base + kx);
    return (base & ~mask) | (low & mask);
  endfunction

  assign col_o = beat_col(base_i, beat_i, len_log_i, order_i);
endmodule

// File: rtl/bcs_counter.sv
module bcs_counter #(
  parameter int COL_W       = 9,
  parameter int LEN_LOG_MAX = 3,
  localparam int CW = $clog2(LEN_LOG_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [COL_W-1:0]       start_col_i,
  input  logic [CW-1:0]          len_code_i,
  input  logic                   ilv_i,
  input  logic                   term_i,
  output logic                   active_o,
  output logic                   at_last_o,
  output logic [LEN_LOG_MAX-1:0] beat_o,
  output logic [CW-1:0]          len_log_o,
  output bcs_pkg::burst_order_e  order_o,
  output logic [COL_W-1:0]       base_o
);
  logic [CW-1:0]          len_log_in;
  logic [LEN_LOG_MAX:0]   span;
  logic [LEN_LOG_MAX-1:0] last_idx;
  logic                   beat_adv;
  logic                   burst_end;

  // Code 0 is read as the shortest burst; codes beyond the maximum clamp.
  always_comb begin
    if (len_code_i == '0)                       len_log_in = CW'(1);
    else if (int'(len_code_i) > LEN_LOG_MAX)    len_log_in = CW'(LEN_LOG_MAX);
    else                                        len_log_in = len_code_i;
  end

  assign span      = ((LEN_LOG_MAX + 1)'(1) << len_log_o) - (LEN_LOG_MAX + 1)'(1);
  assign last_idx  = span[LEN_LOG_MAX-1:0];
  assign at_last_o = active_o && (beat_o == last_idx);
  assign burst_end = active_o && !start_i && (term_i || at_last_o);
  assign beat_adv  = active_o && !start_i && !burst_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o  <= 1'b0;
      beat_o    <= '0;
      len_log_o <= CW'(1);
      order_o   <= bcs_pkg::ORD_SEQ;
      base_o    <= '0;
    end else if (start_i) begin
      active_o  <= 1'b1;
      beat_o    <= '0;
      len_log_o <= len_log_in;
      order_o   <= bcs_pkg::burst_order_e'(ilv_i);
      base_o    <= start_col_i;
    end else if (burst_end) begin
      active_o  <= 1'b0;
      beat_o    <= '0;
    end else if (beat_adv) begin
      beat_o    <= beat_o + 1'b1;
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W       = 9,
  parameter int LEN_LOG_MAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam int CW = $clog2(LEN_LOG_MAX + 1);

  logic                   active;
  logic                   at_last;
  logic [LEN_LOG_MAX-1:0] beat;
  logic [CW-1:0]          len_log;
  bcs_pkg::burst_order_e  order;
  logic [COL_W-1:0]       base;
  logic [COL_W-1:0]       beat_col;

  bcs_counter #(.COL_W(COL_W), .LEN_LOG_MAX(LEN_LOG_MAX)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .start_col_i(start_col_i),
    .len_code_i (CW'(len_code_i)),
    .ilv_i      (ilv_i),
    .term_i     (term_i),
    .active_o   (active),
    .at_last_o  (at_last),
    .beat_o     (beat),
    .len_log_o  (len_log),
    .order_o    (order),
    .base_o     (base)
  );

  bcs_order #(.COL_W(COL_W), .LEN_LOG_MAX(LEN_LOG_MAX)) u_ord (
    .base_i   (base),
    .beat_i   (beat),
    .len_log_i(len_log),
    .order_i  (order),
    .col_o    (beat_col)
  );

  assign valid_o = active;
  assign last_o  = at_last;
  assign col_o   = active ? beat_col : '0;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int COL_W       = 9,
  parameter int LEN_LOG_MAX = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             term_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  // R2
  start_beat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o && (col_o == $past(start_col_i)));
  // R7
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
  // R7
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start_i |=> !valid_o);
  // R8
  term_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && term_i && !start_i |=> !valid_o);
  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o && !term_i && !start_i |=>
      valid_o && (col_o[COL_W-1:LEN_LOG_MAX] == $past(col_o[COL_W-1:LEN_LOG_MAX])));
  // R11
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o && !start_i |=> !valid_o);
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W), .LEN_LOG_MAX(LEN_LOG_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .term_i     (term_i),
  .start_col_i(start_col_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .last_o     (last_o)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [1:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       term_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o;
  logic       last_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int blen(input int code);
    return (code == 0) ? 2 : (1 << code);
  endfunction

  function automatic int exp_col(input int col, input int len, input bit ilv, input int k);
    int off = col % len;
    int blk = col - off;
    return ilv ? blk + (off ^ k) : blk + ((off + k) % len);
  endfunction

  // Walk the beats of a burst already begun; leaves time at the final beat.
  task automatic walk(input int col, input int len, input bit ilv, input string tag);
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk);
      chk({tag, " valid"}, valid_o, 1);
      chk({tag, " col"}, col_o, exp_col(col, len, ilv, k));
      chk({tag, " last R7"}, last_o, (k == len - 1) ? 1 : 0);
    end
  endtask

  task automatic launch(input int col, input int code, input bit ilv);
    start_i = 1'b1; start_col_i = 9'(col); len_code_i = 2'(code); ilv_i = ilv;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", valid_o, 0);
    chk("R1 last in reset", last_o, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", valid_o, 0);
    chk("R1 col after reset", col_o, 0);
  endtask

  task automatic t_full(input int col, input int code, input bit ilv, input string tag);
    @(negedge clk);
    launch(col, code, ilv);
    chk({tag, " R2 beat0"}, col_o, col);
    walk(col, blen(code), ilv, tag);
    @(negedge clk);
    chk({tag, " R3 end"}, valid_o, 0);
  endtask

  task automatic t_term();
    @(negedge clk);
    launch(9'h0A5, 3, 1'b0);
    chk("R8 beat0", col_o, 9'h0A5);
    @(negedge clk);
    @(negedge clk);
    term_i = 1'b1;
    chk("R8 beat2 col", col_o, exp_col(9'h0A5, 8, 0, 2));
    chk("R8 beat2 valid", valid_o, 1);
    @(negedge clk);
    term_i = 1'b0;
    chk("R8 stopped", valid_o, 0);
    chk("R8 no last", last_o, 0);
    @(negedge clk);
    chk("R8 still idle", valid_o, 0);
  endtask

  task automatic t_term_idle();
    @(negedge clk);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    chk("R11 idle term", valid_o, 0);
    t_full(9'h033, 2, 1'b1, "R11 after");
  endtask

  task automatic t_chain();
    @(negedge clk);
    launch(9'h10E, 2, 1'b0);
    walk(9'h10E, 4, 1'b0, "R9 first");
    start_i = 1'b1; start_col_i = 9'h0F9; len_code_i = 2'd3; ilv_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 no gap", valid_o, 1);
    walk(9'h0F9, 8, 1'b1, "R9 second");
    @(negedge clk);
    chk("R9 end", valid_o, 0);
  endtask

  task automatic t_hold_inputs();
    @(negedge clk);
    launch(9'h1C6, 2, 1'b1);
    start_col_i = 9'h000; len_code_i = 2'd3; ilv_i = 1'b0;
    walk(9'h1C6, 4, 1'b1, "R10");
    @(negedge clk);
    chk("R10 length kept", valid_o, 0);
  endtask

  initial begin
    t_reset();
    t_full(9'h001, 1, 1'b0, "R4 len2 seq");
    t_full(9'h0F6, 2, 1'b0, "R4 len4 seq");
    t_full(9'h1FD, 3, 1'b0, "R4 R6 len8 seq");
    t_full(9'h047, 0, 1'b0, "R3 code0");
    t_full(9'h1F5, 3, 1'b1, "R5 R6 len8 ilv");
    t_full(9'h02E, 2, 1'b1, "R5 len4 ilv");
    t_full(9'h155, 1, 1'b1, "R5 len2 ilv");
    t_term();
    t_term_idle();
    t_chain();
    t_hold_inputs();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule